// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block gathers a wide set of peripheral request lines and folds them onto sixteen core priority levels. A bank of assignment registers chooses, for every source, which general-purpose level (7 to 15) it drives. A rising edge on a source marks its level in a pending latch. A per-level mask and a global enable for the general-purpose levels decide which pending levels may compete. An active register records which levels are being serviced or have been interrupted by something more urgent.

The core sees one valid flag and one 4-bit level. The level offered is the lowest-numbered eligible pending level, and it is offered only when it outranks every level already active. Level 0 is the most urgent. When the core acknowledges, the level moves from pending to active on that clock edge. Software ends a handler by writing the return address, which retires the most urgent active level. Levels 0 to 6 have no peripheral sources. Software reaches them by writing the pending latch, and the global enable does not gate them.

Register map, decoded on `reg_addr`: 0 pending latch (16 bits), 1 mask (16 bits), 2 active (read-only), 3 global enable (bit 0), 4 return strobe (write only), 8 to 15 assignment registers 0 to 7. Addresses 5 to 7 read as zero.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset the pending latch, mask, active register, global enable and valid flag are all 0. Assignment field s (source s, bits 4*(s%8)+3..4*(s%8) of assignment register s/8 at address 8+s/8) holds s modulo 9.
- R2: A rising edge on source s sets pending bit L one cycle later, where L = 7+f for field value f up to 8 and L = 15 for f from 9 to 15. A source held high does not set the bit again.
- R3: Sources that map to the same level share one pending bit. Edges on several of them in the same cycle set only that bit.
- R4: A pending level whose mask bit (address 1) is 0 stays latched but is not offered, and it is offered once it is unmasked.
- R5: With the global enable (address 3, bit 0) at 0, levels 7 to 15 are not offered, while levels 0 to 6 still are.
- R6: The pending latch (address 0) is written only while priv_sup is 1, and it reads as 0 while priv_sup is 0.
- R7: irq_level is the lowest-numbered level that is pending, unmasked and enabled. irq_valid is 1 only if that level is lower than the lowest-numbered active bit, or if no bit is active.
- R8: irq_ack while irq_valid is 1 sets the offered level's active bit and clears its pending bit on the same edge. irq_ack while irq_valid is 0 changes nothing.
- R9: A write to address 4 clears only the lowest-numbered set active bit.
- R10: A source edge in the same cycle as a software write to the pending latch is kept in the latch.
- R11: Writes to the active register (address 2) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NUM_SRC | Peripheral request lines, edge-detected |
| priv_sup | input | 1 | 1 when the access comes from supervisor mode |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq_valid | output | 1 | A level is offered to the core |
| irq_level | output | 4 | Offered level, 0 most urgent |
| irq_ack | input | 1 | Core takes the offered level |

## Verification
The hardest state to reach from the ports is a stack several levels deep in which some lower-priority requests are pending, and in which an acknowledge, a return write, a software latch write and fresh source edges land in the same cycle. Directed steps first build a two-deep stack, a masked pending level, a gated general-purpose level beside a software-raised level 3, and a source edge that meets a latch write. A long seeded random run then toggles sources, acknowledges on half the cycles and issues frequent returns, so that nesting keeps growing and shrinking. Every cycle is compared with a bench model built from the requirements.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    localparam int NUM_LVL     = 16;
    localparam int LVL_W       = 4;
    localparam int GP_BASE     = 7;
    localparam int GP_SPAN     = NUM_LVL - GP_BASE;
    localparam int FLD_W       = 4;
    localparam int FLD_PER_REG = 8;
    localparam int REG_W       = FLD_W * FLD_PER_REG;
    localparam int ADDR_W      = 4;
    localparam int IDX_W       = 3;

    typedef logic [NUM_LVL-1:0] lvl_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        ADR_PEND   = 4'd0,
        ADR_MASK   = 4'd1,
        ADR_ACTIVE = 4'd2,
        ADR_GEN    = 4'd3,
        ADR_RETURN = 4'd4
    } adr_e;

    typedef struct packed {
        logic     lat_wr;
        logic     msk_wr;
        logic     gen_wr;
        logic     rti;
        lvl_vec_t data;
    } state_cmd_t;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] level;
    } pick_t;

    // Field value to core level: 7..15, values past 8 saturate at 15.
    function automatic logic [LVL_W-1:0] fld_to_lvl(input logic [FLD_W-1:0] f);
        if (int'(f) >= GP_SPAN - 1) return LVL_W'(NUM_LVL - 1);
        return LVL_W'(GP_BASE) + f;
    endfunction

    function automatic logic [FLD_W-1:0] dflt_fld(input int s);
        return FLD_W'(s % GP_SPAN);
    endfunction

    // Index of the lowest set bit, or NUM_LVL when none is set.
    function automatic logic [LVL_W:0] lowest_set(input lvl_vec_t v);
        logic [LVL_W:0] r;
        r = (LVL_W+1)'(NUM_LVL);
        for (int i = NUM_LVL - 1; i >= 0; i--) begin
            if (v[i]) r = (LVL_W+1)'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_route.sv
module irq_route
    import irq_nest_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_ASG = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_SRC-1:0]       src_req,
    input  logic                     asg_wr,
    input  logic [IDX_W-1:0]         asg_idx,
    input  logic [REG_W-1:0]         asg_wdata,
    output lvl_vec_t                 lvl_set,
    output logic [NUM_ASG*REG_W-1:0] asg_rd
);

    logic [FLD_W-1:0]   fld_q [NUM_SRC];
    logic [NUM_SRC-1:0] prev_q;
    logic [NUM_SRC-1:0] rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            for (int s = 0; s < NUM_SRC; s++) fld_q[s] <= dflt_fld(s);
        end else begin
            prev_q <= src_req;
            if (asg_wr) begin
                for (int s = 0; s < NUM_SRC; s++) begin
                    if (asg_idx == IDX_W'(s / FLD_PER_REG))
                        fld_q[s] <= asg_wdata[(s % FLD_PER_REG)*FLD_W +: FLD_W];
                end
            end
        end
    end

    assign rise = src_req & ~prev_q;

    // Several sources on one level collapse into one set bit.
    always_comb begin
        lvl_set = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (rise[s]) lvl_set[fld_to_lvl(fld_q[s])] = 1'b1;
        end
    end

    for (genvar k = 0; k < NUM_ASG; k++) begin : g_reg
        for (genvar j = 0; j < FLD_PER_REG; j++) begin : g_fld
            if (k*FLD_PER_REG + j < NUM_SRC) begin : g_live
                assign asg_rd[(k*FLD_PER_REG + j)*FLD_W +: FLD_W] = fld_q[k*FLD_PER_REG + j];
            end else begin : g_pad
                assign asg_rd[(k*FLD_PER_REG + j)*FLD_W +: FLD_W] = '0;
            end
        end
    end

endmodule

// File: rtl/irq_state.sv
module irq_state
    import irq_nest_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  lvl_vec_t         lvl_set,
    input  state_cmd_t       cmd,
    input  logic             take,
    input  logic [LVL_W-1:0] take_lvl,
    output lvl_vec_t         lat_q,
    output lvl_vec_t         msk_q,
    output lvl_vec_t         act_q,
    output logic             gen_q
);

    lvl_vec_t       lat_d;
    lvl_vec_t       act_d;
    logic [LVL_W:0] top_act;

    always_comb begin
        // Software write, then the take clears, then new edges win.
        lat_d = cmd.lat_wr ? cmd.data : lat_q;
        if (take) lat_d[take_lvl] = 1'b0;
        lat_d = lat_d | lvl_set;

        top_act = lowest_set(act_q);
        act_d   = act_q;
        if (cmd.rti && !top_act[LVL_W]) act_d[top_act[LVL_W-1:0]] = 1'b0;
        if (take) act_d[take_lvl] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
            msk_q <= '0;
            act_q <= '0;
            gen_q <= 1'b0;
        end else begin
            lat_q <= lat_d;
            act_q <= act_d;
            if (cmd.msk_wr) msk_q <= cmd.data;
            if (cmd.gen_wr) gen_q <= cmd.data[0];
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_nest_pkg::*;
(
    input  lvl_vec_t lat_q,
    input  lvl_vec_t msk_q,
    input  lvl_vec_t act_q,
    input  logic     gen_q,
    output pick_t    pick
);

    lvl_vec_t       gate;
    lvl_vec_t       elig;
    logic [LVL_W:0] cand;
    logic [LVL_W:0] floor_lvl;

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_gate
        if (l < GP_BASE) begin : g_sys
            assign gate[l] = 1'b1;
        end else begin : g_gp
            assign gate[l] = gen_q;
        end
    end

    always_comb begin
        elig       = lat_q & msk_q & gate;
        cand       = lowest_set(elig);
        floor_lvl  = lowest_set(act_q);
        pick.valid = !cand[LVL_W] && (cand < floor_lvl);
        pick.level = cand[LVL_W-1:0];
    end

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               priv_sup,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               irq_valid,
    output logic [LVL_W-1:0]   irq_level,
    input  logic               irq_ack
);

    localparam int NUM_ASG = (NUM_SRC + FLD_PER_REG - 1) / FLD_PER_REG;

    lvl_vec_t                 lvl_set;
    lvl_vec_t                 lat_q;
    lvl_vec_t                 msk_q;
    lvl_vec_t                 act_q;
    logic                     gen_q;
    logic [NUM_ASG*REG_W-1:0] asg_rd;
    logic                     asg_wr;
    state_cmd_t               cmd;
    pick_t                    pick;
    logic                     take;
    logic                     rti_stb;

    assign asg_wr = reg_wr && reg_addr[ADDR_W-1] && (int'(reg_addr[IDX_W-1:0]) < NUM_ASG);

    always_comb begin
        cmd.lat_wr = reg_wr && (reg_addr == ADR_PEND) && priv_sup;
        cmd.msk_wr = reg_wr && (reg_addr == ADR_MASK);
        cmd.gen_wr = reg_wr && (reg_addr == ADR_GEN);
        cmd.rti    = reg_wr && (reg_addr == ADR_RETURN);
        cmd.data   = reg_wdata[NUM_LVL-1:0];
    end

    assign rti_stb   = cmd.rti;
    assign take      = pick.valid && irq_ack;
    assign irq_valid = pick.valid;
    assign irq_level = pick.level;

    irq_route #(
        .NUM_SRC (NUM_SRC),
        .NUM_ASG (NUM_ASG)
    ) u_route (
        .clk       (clk),
        .rst       (rst),
        .src_req   (src_req),
        .asg_wr    (asg_wr),
        .asg_idx   (reg_addr[IDX_W-1:0]),
        .asg_wdata (reg_wdata),
        .lvl_set   (lvl_set),
        .asg_rd    (asg_rd)
    );

    irq_state u_state (
        .clk      (clk),
        .rst      (rst),
        .lvl_set  (lvl_set),
        .cmd      (cmd),
        .take     (take),
        .take_lvl (pick.level),
        .lat_q    (lat_q),
        .msk_q    (msk_q),
        .act_q    (act_q),
        .gen_q    (gen_q)
    );

    irq_arbiter u_arb (
        .lat_q (lat_q),
        .msk_q (msk_q),
        .act_q (act_q),
        .gen_q (gen_q),
        .pick  (pick)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[ADDR_W-1]) begin
            if (int'(reg_addr[IDX_W-1:0]) < NUM_ASG)
                reg_rdata = asg_rd[int'(reg_addr[IDX_W-1:0])*REG_W +: REG_W];
        end else begin
            case (reg_addr)
                ADR_PEND:   if (priv_sup) reg_rdata = REG_W'(lat_q);
                ADR_MASK:   reg_rdata = REG_W'(msk_q);
                ADR_ACTIVE: reg_rdata = REG_W'(act_q);
                ADR_GEN:    reg_rdata = REG_W'(gen_q);
                default:    reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk
    import irq_nest_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              irq_valid,
    input logic [LVL_W-1:0]  irq_level,
    input logic              irq_ack,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              priv_sup,
    input logic [REG_W-1:0]  reg_rdata,
    input lvl_vec_t          lat_q,
    input lvl_vec_t          msk_q,
    input lvl_vec_t          act_q,
    input logic              gen_q,
    input lvl_vec_t          lvl_set,
    input logic              rti
);

    p_offer_unmasked_r4: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (msk_q[irq_level] && lat_q[irq_level]));

    p_gp_gated_r5: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !gen_q) |-> (int'(irq_level) < GP_BASE));

    p_user_read_blank_r6: assert property (@(posedge clk) disable iff (rst)
        (!priv_sup && reg_addr == 4'd0) |-> (reg_rdata == '0));

    p_not_already_active_r7: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> !act_q[irq_level]);

    p_take_marks_active_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && irq_ack) |=> act_q[$past(irq_level)]);

    p_take_clears_pending_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && irq_ack && !lvl_set[irq_level]) |=> !lat_q[$past(irq_level)]);

    p_return_pops_one_r9: assert property (@(posedge clk) disable iff (rst)
        (rti && !(irq_valid && irq_ack) && act_q != '0)
        |=> ($countones(act_q) + 1 == $past($countones(act_q))));

    p_edge_kept_r10: assert property (@(posedge clk) disable iff (rst)
        (lvl_set != '0) |=> ((lat_q & $past(lvl_set)) == $past(lvl_set)));

    p_active_readonly_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 4'd2 && !(irq_valid && irq_ack)) |=> (act_q == $past(act_q)));

endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_valid (irq_valid),
    .irq_level (irq_level),
    .irq_ack   (irq_ack),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .priv_sup  (priv_sup),
    .reg_rdata (reg_rdata),
    .lat_q     (lat_q),
    .msk_q     (msk_q),
    .act_q     (act_q),
    .gen_q     (gen_q),
    .lvl_set   (lvl_set),
    .rti       (rti_stb)
);

// File: tb/irq_nest_ctrl_bench.sv
module irq_nest_ctrl_bench;

    localparam int NSRC = 64;

    logic            clk = 1'b0;
    logic            rst;
    logic [NSRC-1:0] src_req;
    logic            priv_sup;
    logic            reg_wr;
    logic [3:0]      reg_addr;
    logic [31:0]     reg_wdata;
    logic [31:0]     reg_rdata;
    logic            irq_valid;
    logic [3:0]      irq_level;
    logic            irq_ack;

    always #5 clk = ~clk;

    irq_nest_ctrl #(.NUM_SRC(NSRC)) u_irq_nest_ctrl (
        .clk       (clk),
        .rst       (rst),
        .src_req   (src_req),
        .priv_sup  (priv_sup),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_valid (irq_valid),
        .irq_level (irq_level),
        .irq_ack   (irq_ack)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // Bench model, written from the requirements.
    logic [15:0]     m_lat, m_msk, m_act;
    logic            m_gen;
    logic [3:0]      m_fld [NSRC];
    logic [NSRC-1:0] m_prev;

    function automatic int b_lvl(input logic [3:0] f);
        return (f > 4'd8) ? 15 : 7 + int'(f);
    endfunction

    function automatic int b_low(input logic [15:0] v);
        for (int i = 0; i < 16; i++) if (v[i]) return i;
        return 16;
    endfunction

    function automatic logic [15:0] b_elig();
        return m_lat & m_msk & (m_gen ? 16'hffff : 16'h007f);
    endfunction

    function automatic logic [31:0] b_read(input logic [3:0] a, input logic p);
        logic [31:0] r;
        r = '0;
        if (a >= 4'd8) begin
            for (int j = 0; j < 8; j++) r[j*4 +: 4] = m_fld[(int'(a) - 8)*8 + j];
        end else if (a == 4'd0) begin
            if (p) r = {16'h0, m_lat};
        end else if (a == 4'd1) r = {16'h0, m_msk};
        else if (a == 4'd2) r = {16'h0, m_act};
        else if (a == 4'd3) r = {31'h0, m_gen};
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: compare before the edge, advance the model after it.
    task automatic cyc();
        int          cl, al;
        logic        exp_v;
        logic [15:0] setv, nl, na;
        #1;
        cl    = b_low(b_elig());
        al    = b_low(m_act);
        exp_v = (cl < 16) && (cl < al);
        chk("R7 valid", {31'h0, irq_valid}, {31'h0, exp_v});
        if (exp_v) chk("R7 level", {28'h0, irq_level}, 32'(cl));
        chk("R6 R11 readback", reg_rdata, b_read(reg_addr, priv_sup));
        @(posedge clk);
        setv = '0;
        for (int s = 0; s < NSRC; s++)
            if (src_req[s] && !m_prev[s]) setv[b_lvl(m_fld[s])] = 1'b1;
        nl = (reg_wr && reg_addr == 4'd0 && priv_sup) ? reg_wdata[15:0] : m_lat;
        na = m_act;
        if (reg_wr && reg_addr == 4'd4 && al < 16) na[al] = 1'b0;
        if (exp_v && irq_ack) begin
            nl[cl] = 1'b0;
            na[cl] = 1'b1;
        end
        nl = nl | setv;
        if (reg_wr && reg_addr == 4'd1) m_msk = reg_wdata[15:0];
        if (reg_wr && reg_addr == 4'd3) m_gen = reg_wdata[0];
        if (reg_wr && reg_addr >= 4'd8)
            for (int j = 0; j < 8; j++) m_fld[(int'(reg_addr) - 8)*8 + j] = reg_wdata[j*4 +: 4];
        m_lat  = nl;
        m_act  = na;
        m_prev = src_req;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        reg_wr   = 1'b0;
        irq_ack  = 1'b0;
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
        @(negedge clk);
    endtask

    task automatic val_chk(input logic v, input logic [3:0] l, input string tag);
        #1;
        chk(tag, {31'h0, irq_valid}, {31'h0, v});
        if (v) chk(tag, {28'h0, irq_level}, {28'h0, l});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; src_req = '0; priv_sup = 1'b1; reg_wr = 1'b0;
        reg_addr = '0; reg_wdata = '0; irq_ack = 1'b0;
        m_lat = '0; m_msk = '0; m_act = '0; m_gen = 1'b0; m_prev = '0;
        for (int s = 0; s < NSRC; s++) m_fld[s] = 4'(s % 9);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        val_chk(1'b0, 4'd0, "R1 valid after reset");
        rd_chk(4'd0, 32'h0, "R1 pending");
        rd_chk(4'd1, 32'h0, "R1 mask");
        rd_chk(4'd3, 32'h0, "R1 global enable");
        rd_chk(4'd8, 32'h7654_3210, "R1 assignment reg 0");
        rd_chk(4'd9, 32'h6543_2108, "R1 assignment reg 1");

        wr(4'd1, 32'h0000_ffff);
        wr(4'd3, 32'h1);

        // R2: field 12 saturates to level 15, one cycle after the edge
        wr(4'd8, 32'h7654_3C10);
        src_req[2] = 1'b1; cyc();
        val_chk(1'b1, 4'd15, "R2 saturated level");
        rd_chk(4'd0, 32'h0000_8000, "R2 pending bit");
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
        rd_chk(4'd2, 32'h0000_8000, "R8 active set");
        rd_chk(4'd0, 32'h0, "R8 pending cleared");
        rd_chk(4'd0, 32'h0, "R2 held source no relatch");

        // R3: sources 1 and 10 both map to level 8
        src_req[1] = 1'b1; src_req[10] = 1'b1; cyc();
        rd_chk(4'd0, 32'h0000_0100, "R3 shared bit");
        val_chk(1'b1, 4'd8, "R7 nests above 15");
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
        rd_chk(4'd2, 32'h0000_8100, "R8 two deep");

        // R9: return pops the most urgent active level
        wr(4'd4, 32'h0);
        rd_chk(4'd2, 32'h0000_8000, "R9 first return");
        wr(4'd4, 32'h0);
        rd_chk(4'd2, 32'h0, "R9 second return");

        // R4: masked level 9 (source 11) stays pending
        wr(4'd1, 32'h0000_fdff);
        src_req[11] = 1'b1; cyc();
        rd_chk(4'd0, 32'h0000_0200, "R4 latched while masked");
        val_chk(1'b0, 4'd0, "R4 not offered");
        wr(4'd1, 32'h0000_ffff);
        val_chk(1'b1, 4'd9, "R4 offered after unmask");

        // R5: global enable off gates 9 but not 3
        wr(4'd3, 32'h0);
        val_chk(1'b0, 4'd0, "R5 level 9 gated");
        wr(4'd0, 32'h0000_0208);
        val_chk(1'b1, 4'd3, "R5 level 3 still offered");
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
        rd_chk(4'd2, 32'h0000_0008, "R8 level 3 active");
        wr(4'd4, 32'h0);
        wr(4'd3, 32'h1);
        val_chk(1'b1, 4'd9, "R5 level 9 after enable");
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
        wr(4'd4, 32'h0);
        rd_chk(4'd2, 32'h0, "R9 stack empty");

        // R6: user-mode latch write ignored, read blank
        priv_sup = 1'b0;
        wr(4'd0, 32'h0000_0001);
        rd_chk(4'd0, 32'h0, "R6 user read blank");
        priv_sup = 1'b1;
        rd_chk(4'd0, 32'h0, "R6 user write ignored");
        val_chk(1'b0, 4'd0, "R6 nothing offered");

        // R11: active register is read-only
        wr(4'd2, 32'h0000_ffff);
        rd_chk(4'd2, 32'h0, "R11 active unchanged");

        // R10: source 4 (level 11) edge meets a latch write
        src_req[4] = 1'b1;
        wr(4'd0, 32'h0000_0001);
        rd_chk(4'd0, 32'h0000_0801, "R10 edge kept");
        val_chk(1'b1, 4'd0, "R7 level 0 first");
        wr(4'd0, 32'h0);

        // R8: acknowledge with nothing offered changes nothing
        wr(4'd1, 32'h0);
        wr(4'd0, 32'h0000_0010);
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
        rd_chk(4'd2, 32'h0, "R8 idle ack ignored");
        rd_chk(4'd0, 32'h0000_0010, "R8 idle ack keeps pending");
        wr(4'd1, 32'h0000_ffff);

        // Random phase, checked every cycle against the model
        for (int i = 0; i < 3000; i++) begin
            int a;
            if ($urandom % 2 == 0) begin
                int k;
                k = int'($urandom % NSRC);
                src_req[k] = ~src_req[k];
            end
            priv_sup = ($urandom % 4) != 0;
            irq_ack  = $urandom % 2 == 0;
            reg_wr   = ($urandom % 4) == 0;
            case ($urandom % 7)
                0: a = 0;
                1: a = 1;
                2: a = 2;
                3: a = 3;
                4, 5: a = 4;
                default: a = 8 + int'($urandom % 8);
            endcase
            reg_addr  = 4'(a);
            reg_wdata = $urandom;
            if (a == 1) reg_wdata = reg_wdata | 32'h0000_ff0f;
            if (a == 3) reg_wdata[0] = ($urandom % 4) != 0;
            cyc();
        end
        reg_wr = 1'b0; irq_ack = 1'b0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule